// File: doc/BRIEF.md
# Four-Way Age-Counter Replacement Tracker

This block keeps the replacement state of a four-way set-associative cache. Every line of every set carries a valid flag and a two-bit age. Among the valid lines of a set the ages form a strict order: 0 is the line used most recently and 3 is the line used least recently. Tag storage, tag compare and the data arrays sit outside the block. The surrounding cache sends one access per cycle. The access gives the set index, whether the tag compare hit, and the way that hit. The block returns the way a miss must fill.

The victim for the addressed set is a combinational output, so the cache can use it in the same cycle. When an access strobe is present, the set's ages and valid flags are updated at the next rising clock edge. A global invalidate clears every valid flag in every set.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset every set reports `victim_free` = 1 and `victim_way` = 0. Ways are numbered 0 to 3 in binary.
- R2: While the addressed set holds an invalid line, `victim_way` is the lowest-numbered invalid way and `victim_free` is 1, in the same cycle as `acc_set`.
- R3: While all four lines of the addressed set are valid, `victim_free` is 0 and `victim_way` is the way whose age is 3, the least recently used line.
- R4: A miss (`acc_vld`=1, `acc_hit`=0) sets the victim way valid with age 0. It adds one to the age of every other valid line in that set.
- R5: A hit (`acc_vld`=1, `acc_hit`=1) on a valid way sets that way's age to 0. It adds one only to valid lines whose age is smaller than the hit way's previous age. All other lines keep their age.
- R6: A hit that names an invalid way leaves the set unchanged.
- R7: Without `acc_vld` no set changes. An access changes only the set it addresses.
- R8: `inval_all` clears every valid flag of every set at the next edge. It takes precedence over an access in the same cycle.
- R9: The valid lines of a set always have distinct ages. A full set that takes four misses in a row with no hits evicts each of its four ways exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inval_all | input | 1 | Clear the valid flags of all sets at the next edge |
| acc_vld | input | 1 | Access strobe; the addressed set is updated at the next edge |
| acc_set | input | 6 | Set index of the access |
| acc_hit | input | 1 | 1 = tag compare hit, 0 = miss |
| acc_way | input | 2 | Way that hit (used only when acc_hit = 1) |
| victim_way | output | 2 | Way to fill on a miss for the addressed set |
| victim_free | output | 1 | 1 when victim_way is an invalid line |

## Verification
`victim_way` and `victim_free` depend combinationally on `acc_set` and the stored state, so they are due in the same cycle the set index is applied. The bench drives inputs on the falling edge and samples the outputs 1 ns later. An access, hit, or invalidate becomes visible only after the following rising edge. Each such effect is therefore checked by the victim and free values seen on the next falling edge, against a reference model that the bench advances after that edge. The sequences include a documented reuse pattern in one set, a pseudo-random stream over all 64 sets, hits on invalid ways, idle sweeps, and an invalidate that collides with an access.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Associativity of the cache; the age width follows from it.
  localparam int unsigned WAYS  = 4;
  localparam int unsigned WAY_W = $clog2(WAYS);

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [WAY_W-1:0] age_t;

  typedef struct packed {
    logic vld;
    age_t age;
  } line_t;

  localparam age_t AGE_OLDEST = age_t'(WAYS - 1);
endpackage

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
  import lru_pkg::*;
(
  input  line_t [WAYS-1:0] lines_i,
  output way_t             victim_o,
  output logic             free_o
);

  always_comb begin
    victim_o = '0;
    free_o   = 1'b0;
    // Oldest line; meaningful once every line is valid.
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lines_i[w].age == AGE_OLDEST) victim_o = way_t'(w);
    end
    // Any invalid line wins; descending scan leaves the lowest index.
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!lines_i[w].vld) begin
        victim_o = way_t'(w);
        free_o   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lru_age_next.sv
module lru_age_next
  import lru_pkg::*;
(
  input  line_t [WAYS-1:0] lines_i,
  input  logic             hit_i,
  input  way_t             hit_way_i,
  input  way_t             fill_way_i,
  output line_t [WAYS-1:0] lines_o
);

  age_t ref_age;
  logic hit_ok;

  always_comb begin
    ref_age = lines_i[hit_way_i].age;
    hit_ok  = lines_i[hit_way_i].vld;
    lines_o = lines_i;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_i) begin
        if (hit_ok) begin
          if (way_t'(w) == hit_way_i) begin
            lines_o[w].age = '0;
          end else if (lines_i[w].vld && (lines_i[w].age < ref_age)) begin
            lines_o[w].age = lines_i[w].age + age_t'(1);
          end
        end
      end else begin
        if (way_t'(w) == fill_way_i) begin
          lines_o[w].vld = 1'b1;
          lines_o[w].age = '0;
        end else if (lines_i[w].vld) begin
          lines_o[w].age = lines_i[w].age + age_t'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
  import lru_pkg::*;
#(
  parameter  int unsigned NUM_SETS = 64,
  localparam int unsigned SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval_all,
  input  logic             acc_vld,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  way_t             acc_way,
  output way_t             victim_way,
  output logic             victim_free
);

  line_t [WAYS-1:0] set_q [NUM_SETS];
  line_t [WAYS-1:0] set_d [NUM_SETS];
  logic  [NUM_SETS-1:0] set_en;

  line_t [WAYS-1:0] cur_lines;
  line_t [WAYS-1:0] upd_lines;

  assign cur_lines = set_q[acc_set];

  lru_victim_sel u_vsel (
    .lines_i  (cur_lines),
    .victim_o (victim_way),
    .free_o   (victim_free)
  );

  lru_age_next u_next (
    .lines_i    (cur_lines),
    .hit_i      (acc_hit),
    .hit_way_i  (acc_way),
    .fill_way_i (victim_way),
    .lines_o    (upd_lines)
  );

  // Per-set enable and next state; invalidate overrides the access.
  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      set_en[s] = inval_all | (acc_vld & (acc_set == SET_W'(s)));
      set_d[s]  = inval_all ? '0 : upd_lines;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) set_q[s] <= '0;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (set_en[s]) set_q[s] <= set_d[s];
      end
    end
  end

endmodule

// File: rtl/lru_age_chk.sv
module lru_age_chk
  import lru_pkg::*;
#(
  parameter  int unsigned NUM_SETS = 64,
  localparam int unsigned SET_W    = $clog2(NUM_SETS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inval_all,
  input logic             acc_vld,
  input logic [SET_W-1:0] acc_set,
  input logic             acc_hit,
  input way_t             acc_way,
  input way_t             victim_way,
  input logic             victim_free,
  input line_t [WAYS-1:0] state_i [NUM_SETS]
);

  localparam int unsigned SET_BITS = WAYS * $bits(line_t);

  logic [NUM_SETS*SET_BITS-1:0] flat;
  logic                         any_vld;
  line_t [WAYS-1:0]             cur;
  logic [SET_W-1:0]             pv_set;
  way_t                         pv_way;

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < NUM_SETS; s++) begin
      flat[s*SET_BITS +: SET_BITS] = state_i[s];
      for (int w = 0; w < WAYS; w++) any_vld = any_vld | state_i[s][w].vld;
    end
  end

  assign cur = state_i[acc_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_set <= '0;
      pv_way <= '0;
    end else begin
      pv_set <= acc_set;
      pv_way <= victim_way;
    end
  end

  function automatic logic ages_distinct(input line_t [WAYS-1:0] l);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      for (int j = i + 1; j < WAYS; j++) begin
        if (l[i].vld && l[j].vld && (l[i].age == l[j].age)) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  // R2
  free_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_free |-> !cur[victim_way].vld);

  // R3
  full_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_free |-> (cur[victim_way].age == AGE_OLDEST));

  // R4
  fill_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_hit && !inval_all) |=>
      (state_i[pv_set][pv_way].vld && (state_i[pv_set][pv_way].age == '0)));

  // R6
  hit_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_hit && !cur[acc_way].vld && !inval_all) |=> $stable(flat));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld && !inval_all) |=> $stable(flat));

  // R8
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !any_vld);

  // R9
  ages_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ages_distinct(cur));

endmodule

bind lru_age_tracker lru_age_chk #(.NUM_SETS(NUM_SETS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .inval_all   (inval_all),
  .acc_vld     (acc_vld),
  .acc_set     (acc_set),
  .acc_hit     (acc_hit),
  .acc_way     (acc_way),
  .victim_way  (victim_way),
  .victim_free (victim_free),
  .state_i     (set_q)
);

// File: tb/lru_age_tracker_tb.sv
`timescale 1ns/1ps
module lru_age_tracker_tb_top;

  localparam int NSETS = 64;
  localparam int NWAYS = 4;

  logic       clk;
  logic       rst_n;
  logic       inval_all;
  logic       acc_vld;
  logic [5:0] acc_set;
  logic       acc_hit;
  logic [1:0] acc_way;
  logic [1:0] victim_way;
  logic       victim_free;

  lru_age_tracker #(.NUM_SETS(NSETS)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .inval_all   (inval_all),
    .acc_vld     (acc_vld),
    .acc_set     (acc_set),
    .acc_hit     (acc_hit),
    .acc_way     (acc_way),
    .victim_way  (victim_way),
    .victim_free (victim_free)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  bit    m_vld [NSETS][NWAYS];
  int    m_age [NSETS][NWAYS];
  int    m_tag [NSETS][NWAYS];
  string last_op [NSETS];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int exp_victim(int s);
    for (int w = 0; w < NWAYS; w++) if (!m_vld[s][w]) return w;
    for (int w = 0; w < NWAYS; w++) if (m_age[s][w] == NWAYS - 1) return w;
    return 0;
  endfunction

  function automatic bit exp_free(int s);
    for (int w = 0; w < NWAYS; w++) if (!m_vld[s][w]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < NSETS; s++) begin
      for (int w = 0; w < NWAYS; w++) begin
        m_vld[s][w] = 1'b0;
        m_age[s][w] = 0;
        m_tag[s][w] = -1;
      end
    end
  endtask

  // Victim and free flag of set s, compared with the model; req names the
  // requirement the checked state depends on.
  task automatic look(int s, string req);
    chk(req, $sformatf("victim set %0d", s), int'(victim_way), exp_victim(s));
    chk(exp_free(s) ? "R2" : "R3", $sformatf("free set %0d", s),
        int'(victim_free), int'(exp_free(s)));
  endtask

  task automatic model_update(int s, bit hit, int way, int fill);
    if (hit) begin
      if (m_vld[s][way]) begin
        int old;
        old = m_age[s][way];
        for (int w = 0; w < NWAYS; w++) begin
          if (w == way) m_age[s][w] = 0;
          else if (m_vld[s][w] && m_age[s][w] < old) m_age[s][w]++;
        end
      end
    end else begin
      for (int w = 0; w < NWAYS; w++) begin
        if (w == fill) begin
          m_vld[s][w] = 1'b1;
          m_age[s][w] = 0;
        end else if (m_vld[s][w]) begin
          m_age[s][w]++;
        end
      end
    end
  endtask

  // One lookup by tag: the bench plays the tag array.
  task automatic access(int s, int tag, output int victim_seen);
    bit hit;
    int hw;
    int ev;
    hit = 1'b0;
    hw  = 0;
    for (int w = 0; w < NWAYS; w++) begin
      if (m_vld[s][w] && m_tag[s][w] == tag) begin
        hit = 1'b1;
        hw  = w;
      end
    end
    @(negedge clk);
    acc_vld = 1'b1;
    acc_set = 6'(s);
    acc_hit = hit;
    acc_way = 2'(hw);
    #1;
    look(s, last_op[s]);
    victim_seen = int'(victim_way);
    ev = exp_victim(s);
    model_update(s, hit, hw, ev);
    if (!hit) m_tag[s][ev] = tag;
    last_op[s] = hit ? "R5" : "R4";
  endtask

  task automatic bogus_hit(int s, int way);
    @(negedge clk);
    acc_vld = 1'b1;
    acc_set = 6'(s);
    acc_hit = 1'b1;
    acc_way = 2'(way);
    #1;
    look(s, last_op[s]);
    last_op[s] = "R6";
  endtask

  task automatic idle_sweep(string req);
    @(negedge clk);
    acc_vld = 1'b0;
    acc_hit = 1'b0;
    for (int s = 0; s < NSETS; s++) begin
      acc_set = 6'(s);
      #1;
      look(s, req);
    end
  endtask

  initial begin
    int v;
    int seq_tags [11];
    int mask;
    rst_n     = 1'b0;
    inval_all = 1'b0;
    acc_vld   = 1'b0;
    acc_set   = '0;
    acc_hit   = 1'b0;
    acc_way   = '0;
    clear_model();
    for (int s = 0; s < NSETS; s++) last_op[s] = "R4";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every set empty after reset
    idle_sweep("R1");

    // R5: reuse pattern in set 0 (line addresses 0,64,128,... fold to set 0)
    seq_tags = '{0, 1, 2, 1, 3, 4, 2, 0, 4, 3, 1};
    for (int i = 0; i < 11; i++) begin
      access(0, seq_tags[i], v);
      if (i == 5)  chk("R3", "oldest evicted at step 6", v, 0);
      if (i == 7)  chk("R5", "oldest after hit reorder, step 8", v, 1);
      if (i == 10) chk("R5", "oldest after two hits, step 11", v, 2);
    end

    // R6: hit on invalid way of an empty set leaves it untouched
    bogus_hit(5, 2);
    bogus_hit(5, 3);
    for (int i = 0; i < 4; i++) begin
      access(5, 100 + i, v);
      chk("R6", "fill order after bogus hits", v, i);
    end

    // R9: full set, four new tags evict four distinct ways
    mask = 0;
    for (int i = 0; i < 4; i++) begin
      access(5, 200 + i, v);
      mask = mask | (1 << v);
    end
    chk("R9", "ways evicted by four misses (mask)", mask, 15);

    // R7: pseudo-random stream over all sets, then idle sweep
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(int'(lfsr[5:0]) % 16, int'(lfsr[11:8]) % 6, v);
    end
    for (int i = 0; i < 1000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(int'(lfsr[5:0]), int'(lfsr[10:8]) % 7, v);
    end
    idle_sweep("R7");
    repeat (5) @(negedge clk);
    idle_sweep("R7");

    // R8: invalidate colliding with a miss on set 3
    @(negedge clk);
    inval_all = 1'b1;
    acc_vld   = 1'b1;
    acc_set   = 6'd3;
    acc_hit   = 1'b0;
    @(negedge clk);
    inval_all = 1'b0;
    acc_vld   = 1'b0;
    clear_model();
    idle_sweep("R8");

    // R4: fresh fills after invalidate
    for (int i = 0; i < 6; i++) access(63, i, v);
    idle_sweep("R4");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule